// File: doc/BRIEF.md
# Ring Queue Doorbell and Pointer Tracker

This block holds the head and tail pointers of a set of paired submission and completion ring queues. Host software reaches it through register writes that land in a doorbell window. For every submission queue the host moves the producer tail. For every completion queue the host moves the consumer head. The command engine moves the other pointer of each ring with one-cycle advance strobes: it consumes a submission entry, or it posts a completion entry. Completion rings keep a phase tag that inverts each time their tail wraps.

The doorbell window starts at byte offset 0x1000 and interleaves the two directions with an 8-byte stride per queue index. The tracker rejects writes that are misaligned, that fall outside the window, that name a queue index that does not exist or is not created, or that carry a pointer value at or beyond the queue size. A head update to a completion ring that was full re-arms its producers. That update emits a kick pulse for the completion poster, together with a mask of every submission queue bound to that ring. A head update that leaves entries outstanding raises a one-cycle interrupt request when the ring has interrupts enabled. Queue creation and deletion come from a side port driven by the admin command logic. A select port exposes the pointers and status of one queue at a time.

Top module: `qring_doorbell`

## Requirements
- R1: A write to byte address 0x1000 + 8*q sets the tail of submission queue q. A write to 0x1000 + 8*q + 4 sets the head of completion queue q. Only the low PTR_W (16) bits of the data are used. Addresses below 0x1000 are ignored.
- R2: A doorbell write whose address has either of its two low bits set changes no pointer.
- R3: A doorbell write to a queue index of NUM_Q or more, or to a queue that is not created or has been deleted, changes no pointer. Consume and post strobes to such a queue are also ignored.
- R4: A doorbell value greater than or equal to the size of the addressed queue is ignored.
- R5: Creating a queue with a size of 2 or more marks it valid, loads the size and clears head and tail. A created completion queue starts with phase 1 and latches its interrupt enable. A create with a size below 2 is refused.
- R6: A consume strobe advances the submission head by one and wraps from size-1 to 0. A consume strobe on an empty queue is ignored.
- R7: A post strobe advances the completion tail by one and wraps from size-1 to 0. The phase toggles on each wrap. A post strobe on a full queue is ignored.
- R8: A submission queue reads empty when head equals tail, and an uncreated one also reads empty. A completion queue reads full when (tail+1) mod size equals head. It reads pending when tail differs from head. Both read 0 for an uncreated queue.
- R9: In the cycle after an accepted completion-head write, irqValid pulses for one cycle with irqId = q. This happens only if the queue has interrupts enabled and its tail differs from the new head.
- R10: If the completion queue was full just before an accepted head write, kickCqValid pulses in the next cycle with kickCqId = q. In the same cycle kickSqMask has bit s set for each created submission queue s bound to q.
- R11: After reset every queue is uncreated, all pointers read 0, the phase reads 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register byte address |
| wrData | input | DATA_W | Register write data |
| sqCreate | input | 1 | Create submission queue sqId |
| sqDelete | input | 1 | Delete submission queue sqId |
| sqId | input | QW | Submission queue index for create/delete |
| sqSize | input | PTR_W | Entry count of the created submission queue |
| sqCqId | input | QW | Completion queue the new submission queue feeds |
| cqCreate | input | 1 | Create completion queue cqId |
| cqDelete | input | 1 | Delete completion queue cqId |
| cqId | input | QW | Completion queue index for create/delete |
| cqSize | input | PTR_W | Entry count of the created completion queue |
| cqIrqEn | input | 1 | Interrupt enable of the created completion queue |
| sqConsume | input | 1 | Command engine consumed one submission entry |
| sqConsumeId | input | QW | Queue of the consumed entry |
| cqPost | input | 1 | Command engine posted one completion entry |
| cqPostId | input | QW | Queue of the posted entry |
| qSel | input | QW | Queue shown on the status outputs |
| sqValidO | output | 1 | Selected submission queue is created |
| sqHeadO | output | PTR_W | Selected submission head |
| sqTailO | output | PTR_W | Selected submission tail |
| sqEmptyO | output | 1 | Selected submission queue empty |
| cqValidO | output | 1 | Selected completion queue is created |
| cqHeadO | output | PTR_W | Selected completion head |
| cqTailO | output | PTR_W | Selected completion tail |
| cqPhaseO | output | 1 | Selected completion phase tag |
| cqFullO | output | 1 | Selected completion queue full |
| cqPendingO | output | 1 | Selected completion queue has unread entries |
| irqValid | output | 1 | Interrupt request pulse |
| irqId | output | QW | Queue of the interrupt request |
| kickCqValid | output | 1 | Re-arm pulse for the completion poster |
| kickCqId | output | QW | Completion queue being re-armed |
| kickSqMask | output | NUM_Q | Submission queues to re-arm |

## Verification
The assertions assume that create and delete never target the queue being consumed from or posted to in the same cycle. They also assume that qSel may move between any two cycles, so each pointer-stability property is qualified by an unchanged qSel. The stimulus drives one operation per cycle and changes the selector only in the idle half of the clock. Every ignored-write property therefore sees a quiet cycle on the other inputs.

// File: rtl/qring_pkg.sv
package qring_pkg;

  // Accepted doorbell updates handed from control to the pointer store.
  typedef struct packed {
    logic sqTailWr;
    logic cqHeadWr;
  } dbStrobe_t;

  // Byte stride between queue indices in the doorbell window.
  localparam int DB_STRIDE_SHIFT = 3;
  // Byte offset of the completion-head doorbell inside one stride.
  localparam int DB_CQ_BIT = 2;

endpackage

// File: rtl/qring_ptr_store.sv
module qring_ptr_store
  import qring_pkg::*;
#(
  parameter int NUM_Q = 64,
  parameter int PTR_W = 16,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dbStrobe_t        strb,
  input  logic [QW-1:0]    dbQid,
  input  logic [PTR_W-1:0] dbValue,
  input  logic             sqCreate,
  input  logic             sqDelete,
  input  logic [QW-1:0]    sqId,
  input  logic [PTR_W-1:0] sqSize,
  input  logic [QW-1:0]    sqCqId,
  input  logic             cqCreate,
  input  logic             cqDelete,
  input  logic [QW-1:0]    cqId,
  input  logic [PTR_W-1:0] cqSize,
  input  logic             cqIrqEn,
  input  logic             sqConsume,
  input  logic [QW-1:0]    sqConsumeId,
  input  logic             cqPost,
  input  logic [QW-1:0]    cqPostId,
  input  logic [QW-1:0]    qSel,
  // lookup of the doorbell-addressed queue
  output logic             lkSqValid,
  output logic [PTR_W-1:0] lkSqSize,
  output logic             lkCqValid,
  output logic [PTR_W-1:0] lkCqSize,
  output logic [PTR_W-1:0] lkCqTail,
  output logic             lkCqFull,
  output logic             lkCqIrqEn,
  output logic [NUM_Q-1:0] lkBindMask,
  // status of the selected queue
  output logic             sqValidO,
  output logic [PTR_W-1:0] sqHeadO,
  output logic [PTR_W-1:0] sqTailO,
  output logic             sqEmptyO,
  output logic             cqValidO,
  output logic [PTR_W-1:0] cqHeadO,
  output logic [PTR_W-1:0] cqTailO,
  output logic             cqPhaseO,
  output logic             cqFullO,
  output logic             cqPendingO
);

  localparam logic [PTR_W-1:0] MIN_SIZE = PTR_W'(2);

  logic [NUM_Q-1:0] sqValidV;
  logic [NUM_Q-1:0] sqEmptyV;
  logic [NUM_Q-1:0] cqValidV;
  logic [NUM_Q-1:0] cqFullV;
  logic [NUM_Q-1:0] cqPendV;
  logic [NUM_Q-1:0] cqPhaseV;
  logic [NUM_Q-1:0] cqIrqV;
  logic [PTR_W-1:0] sqHeadA [NUM_Q];
  logic [PTR_W-1:0] sqTailA [NUM_Q];
  logic [PTR_W-1:0] sqSizeA [NUM_Q];
  logic [PTR_W-1:0] cqHeadA [NUM_Q];
  logic [PTR_W-1:0] cqTailA [NUM_Q];
  logic [PTR_W-1:0] cqSizeA [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    // ---------------- submission ring ----------------
    logic             sqV;
    logic [PTR_W-1:0] sqH;
    logic [PTR_W-1:0] sqT;
    logic [PTR_W-1:0] sqS;
    logic [QW-1:0]    sqC;
    logic             sqMk;
    logic             sqKill;
    logic             sqTake;
    logic [PTR_W-1:0] sqHNext;

    assign sqMk    = sqCreate && (sqId == QW'(q)) && (sqSize >= MIN_SIZE);
    assign sqKill  = sqDelete && (sqId == QW'(q));
    assign sqTake  = sqConsume && (sqConsumeId == QW'(q)) && sqV && (sqH != sqT);
    assign sqHNext = (sqH == sqS - 1'b1) ? '0 : sqH + 1'b1;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sqV <= 1'b0;
        sqH <= '0;
        sqT <= '0;
        sqS <= '0;
        sqC <= '0;
      end else if (sqMk) begin
        sqV <= 1'b1;
        sqH <= '0;
        sqT <= '0;
        sqS <= sqSize;
        sqC <= sqCqId;
      end else if (sqKill) begin
        sqV <= 1'b0;
      end else begin
        if (strb.sqTailWr && (dbQid == QW'(q))) sqT <= dbValue;
        if (sqTake) sqH <= sqHNext;
      end
    end

    // ---------------- completion ring ----------------
    logic             cqV;
    logic [PTR_W-1:0] cqH;
    logic [PTR_W-1:0] cqT;
    logic [PTR_W-1:0] cqS;
    logic             cqP;
    logic             cqI;
    logic             cqMk;
    logic             cqKill;
    logic             cqWrap;
    logic [PTR_W-1:0] cqTNext;
    logic             cqFullQ;
    logic             cqGive;

    assign cqMk    = cqCreate && (cqId == QW'(q)) && (cqSize >= MIN_SIZE);
    assign cqKill  = cqDelete && (cqId == QW'(q));
    assign cqWrap  = (cqT == cqS - 1'b1);
    assign cqTNext = cqWrap ? '0 : cqT + 1'b1;
    assign cqFullQ = cqV && (cqTNext == cqH);
    assign cqGive  = cqPost && (cqPostId == QW'(q)) && cqV && !cqFullQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cqV <= 1'b0;
        cqH <= '0;
        cqT <= '0;
        cqS <= '0;
        cqP <= 1'b0;
        cqI <= 1'b0;
      end else if (cqMk) begin
        cqV <= 1'b1;
        cqH <= '0;
        cqT <= '0;
        cqS <= cqSize;
        cqP <= 1'b1;
        cqI <= cqIrqEn;
      end else if (cqKill) begin
        cqV <= 1'b0;
      end else begin
        if (strb.cqHeadWr && (dbQid == QW'(q))) cqH <= dbValue;
        if (cqGive) begin
          cqT <= cqTNext;
          if (cqWrap) cqP <= ~cqP;
        end
      end
    end

    assign sqValidV[q]   = sqV;
    assign sqEmptyV[q]   = !sqV || (sqH == sqT);
    assign cqValidV[q]   = cqV;
    assign cqFullV[q]    = cqFullQ;
    assign cqPendV[q]    = cqV && (cqT != cqH);
    assign cqPhaseV[q]   = cqP;
    assign cqIrqV[q]     = cqI;
    assign lkBindMask[q] = sqV && (sqC == dbQid);
    assign sqHeadA[q]    = sqH;
    assign sqTailA[q]    = sqT;
    assign sqSizeA[q]    = sqS;
    assign cqHeadA[q]    = cqH;
    assign cqTailA[q]    = cqT;
    assign cqSizeA[q]    = cqS;
  end

  // doorbell lookup
  assign lkSqValid = sqValidV[dbQid];
  assign lkSqSize  = sqSizeA[dbQid];
  assign lkCqValid = cqValidV[dbQid];
  assign lkCqSize  = cqSizeA[dbQid];
  assign lkCqTail  = cqTailA[dbQid];
  assign lkCqFull  = cqFullV[dbQid];
  assign lkCqIrqEn = cqIrqV[dbQid];

  // selected status
  assign sqValidO   = sqValidV[qSel];
  assign sqHeadO    = sqHeadA[qSel];
  assign sqTailO    = sqTailA[qSel];
  assign sqEmptyO   = sqEmptyV[qSel];
  assign cqValidO   = cqValidV[qSel];
  assign cqHeadO    = cqHeadA[qSel];
  assign cqTailO    = cqTailA[qSel];
  assign cqPhaseO   = cqPhaseV[qSel];
  assign cqFullO    = cqFullV[qSel];
  assign cqPendingO = cqPendV[qSel];

endmodule

// File: rtl/qring_db_ctrl.sv
module qring_db_ctrl
  import qring_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DB_BASE = 'h1000,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lkSqValid,
  input  logic [PTR_W-1:0]  lkSqSize,
  input  logic              lkCqValid,
  input  logic [PTR_W-1:0]  lkCqSize,
  input  logic [PTR_W-1:0]  lkCqTail,
  input  logic              lkCqFull,
  input  logic              lkCqIrqEn,
  input  logic [NUM_Q-1:0]  lkBindMask,
  output dbStrobe_t         strb,
  output logic [QW-1:0]     dbQid,
  output logic [PTR_W-1:0]  dbValue,
  output logic              irqValid,
  output logic [QW-1:0]     irqId,
  output logic              kickCqValid,
  output logic [QW-1:0]     kickCqId,
  output logic [NUM_Q-1:0]  kickSqMask
);

  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(DB_BASE);
  localparam logic [ADDR_W-1:0] QLIM  = ADDR_W'(NUM_Q);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] qidWide;
  logic              inRegion;
  logic              aligned;
  logic              inRange;
  logic              isCqDb;
  logic              hit;
  logic              cqWasFull;
  logic [DATA_W-PTR_W-1:0] unusedHiData;

  assign offset   = wrAddr - BASE;
  assign qidWide  = offset >> DB_STRIDE_SHIFT;
  assign inRegion = (wrAddr >= BASE);
  assign aligned  = (wrAddr[1:0] == 2'b00);
  assign inRange  = (qidWide < QLIM);
  assign isCqDb   = offset[DB_CQ_BIT];
  assign hit      = wrEn && inRegion && aligned && inRange;

  assign dbQid        = qidWide[QW-1:0];
  assign dbValue      = wrData[PTR_W-1:0];
  assign unusedHiData = wrData[DATA_W-1:PTR_W];

  assign strb.sqTailWr = hit && !isCqDb && lkSqValid && (dbValue < lkSqSize);
  assign strb.cqHeadWr = hit &&  isCqDb && lkCqValid && (dbValue < lkCqSize);
  assign cqWasFull     = strb.cqHeadWr && lkCqFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid    <= 1'b0;
      irqId       <= '0;
      kickCqValid <= 1'b0;
      kickCqId    <= '0;
      kickSqMask  <= '0;
    end else begin
      irqValid    <= strb.cqHeadWr && lkCqIrqEn && (lkCqTail != dbValue);
      irqId       <= dbQid;
      kickCqValid <= cqWasFull;
      kickCqId    <= dbQid;
      kickSqMask  <= cqWasFull ? lkBindMask : '0;
    end
  end

endmodule

// File: rtl/qring_doorbell.sv
module qring_doorbell
  import qring_pkg::*;
#(
  parameter int NUM_Q   = 64,
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DB_BASE = 'h1000,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sqCreate,
  input  logic              sqDelete,
  input  logic [QW-1:0]     sqId,
  input  logic [PTR_W-1:0]  sqSize,
  input  logic [QW-1:0]     sqCqId,
  input  logic              cqCreate,
  input  logic              cqDelete,
  input  logic [QW-1:0]     cqId,
  input  logic [PTR_W-1:0]  cqSize,
  input  logic              cqIrqEn,
  input  logic              sqConsume,
  input  logic [QW-1:0]     sqConsumeId,
  input  logic              cqPost,
  input  logic [QW-1:0]     cqPostId,
  input  logic [QW-1:0]     qSel,
  output logic              sqValidO,
  output logic [PTR_W-1:0]  sqHeadO,
  output logic [PTR_W-1:0]  sqTailO,
  output logic              sqEmptyO,
  output logic              cqValidO,
  output logic [PTR_W-1:0]  cqHeadO,
  output logic [PTR_W-1:0]  cqTailO,
  output logic              cqPhaseO,
  output logic              cqFullO,
  output logic              cqPendingO,
  output logic              irqValid,
  output logic [QW-1:0]     irqId,
  output logic              kickCqValid,
  output logic [QW-1:0]     kickCqId,
  output logic [NUM_Q-1:0]  kickSqMask
);

  dbStrobe_t        strb;
  logic [QW-1:0]    dbQid;
  logic [PTR_W-1:0] dbValue;
  logic             lkSqValid;
  logic [PTR_W-1:0] lkSqSize;
  logic             lkCqValid;
  logic [PTR_W-1:0] lkCqSize;
  logic [PTR_W-1:0] lkCqTail;
  logic             lkCqFull;
  logic             lkCqIrqEn;
  logic [NUM_Q-1:0] lkBindMask;

  qring_db_ctrl #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DB_BASE(DB_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lkSqValid(lkSqValid), .lkSqSize(lkSqSize),
    .lkCqValid(lkCqValid), .lkCqSize(lkCqSize), .lkCqTail(lkCqTail),
    .lkCqFull(lkCqFull), .lkCqIrqEn(lkCqIrqEn), .lkBindMask(lkBindMask),
    .strb(strb), .dbQid(dbQid), .dbValue(dbValue),
    .irqValid(irqValid), .irqId(irqId),
    .kickCqValid(kickCqValid), .kickCqId(kickCqId), .kickSqMask(kickSqMask)
  );

  qring_ptr_store #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .strb(strb), .dbQid(dbQid), .dbValue(dbValue),
    .sqCreate(sqCreate), .sqDelete(sqDelete), .sqId(sqId), .sqSize(sqSize), .sqCqId(sqCqId),
    .cqCreate(cqCreate), .cqDelete(cqDelete), .cqId(cqId), .cqSize(cqSize), .cqIrqEn(cqIrqEn),
    .sqConsume(sqConsume), .sqConsumeId(sqConsumeId),
    .cqPost(cqPost), .cqPostId(cqPostId), .qSel(qSel),
    .lkSqValid(lkSqValid), .lkSqSize(lkSqSize),
    .lkCqValid(lkCqValid), .lkCqSize(lkCqSize), .lkCqTail(lkCqTail),
    .lkCqFull(lkCqFull), .lkCqIrqEn(lkCqIrqEn), .lkBindMask(lkBindMask),
    .sqValidO(sqValidO), .sqHeadO(sqHeadO), .sqTailO(sqTailO), .sqEmptyO(sqEmptyO),
    .cqValidO(cqValidO), .cqHeadO(cqHeadO), .cqTailO(cqTailO), .cqPhaseO(cqPhaseO),
    .cqFullO(cqFullO), .cqPendingO(cqPendingO)
  );

endmodule

// File: rtl/qring_doorbell_chk.sv
module qring_doorbell_chk #(
  parameter int NUM_Q  = 64,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              sqCreate,
  input logic              sqDelete,
  input logic              cqCreate,
  input logic              cqDelete,
  input logic              sqConsume,
  input logic [QW-1:0]     sqConsumeId,
  input logic              cqPost,
  input logic [QW-1:0]     cqPostId,
  input logic [QW-1:0]     qSel,
  input logic [PTR_W-1:0]  sqHeadO,
  input logic [PTR_W-1:0]  sqTailO,
  input logic              sqEmptyO,
  input logic [PTR_W-1:0]  cqHeadO,
  input logic [PTR_W-1:0]  cqTailO,
  input logic              cqPhaseO,
  input logic              cqFullO,
  input logic              cqPendingO,
  input logic              irqValid,
  input logic              kickCqValid,
  input logic [NUM_Q-1:0]  kickSqMask
);

  logic quietSide;
  assign quietSide = !sqCreate && !sqDelete && !cqCreate && !cqDelete && !sqConsume && !cqPost;

  // R9
  irq_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> $past(wrEn));

  // R10
  kick_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    kickCqValid |-> $past(wrEn));

  // R10
  mask_needs_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kickSqMask != '0) |-> kickCqValid);

  // R2
  misaligned_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ((wrAddr & ADDR_W'(3)) != '0) && quietSide) |=>
      ((qSel != $past(qSel)) || ($stable(sqTailO) && $stable(cqHeadO))));

  // R7
  full_post_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cqPost && (cqPostId == qSel) && cqFullO && !cqCreate && !cqDelete) |=>
      ((qSel != $past(qSel)) || ($stable(cqTailO) && $stable(cqPhaseO))));

  // R6
  empty_consume_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sqConsume && (sqConsumeId == qSel) && sqEmptyO && !sqCreate && !sqDelete) |=>
      ((qSel != $past(qSel)) || $stable(sqHeadO)));

  // R8
  full_implies_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    cqFullO |-> cqPendingO);

endmodule

bind qring_doorbell qring_doorbell_chk #(
  .NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_qring_doorbell.sv
module test_qring_doorbell;

  localparam int CLK_PERIOD = 20;
  localparam int NQ   = 4;
  localparam int QW   = 2;
  localparam int PW   = 16;
  localparam int AW   = 16;
  localparam int BASE = 'h1000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [31:0]   wrData;
  logic          sqCreate, sqDelete, cqCreate, cqDelete, cqIrqEn, sqConsume, cqPost;
  logic [QW-1:0] sqId, sqCqId, cqId, sqConsumeId, cqPostId, qSel;
  logic [PW-1:0] sqSize, cqSize;
  logic          sqValidO, sqEmptyO, cqValidO, cqPhaseO, cqFullO, cqPendingO;
  logic [PW-1:0] sqHeadO, sqTailO, cqHeadO, cqTailO;
  logic          irqValid, kickCqValid;
  logic [QW-1:0] irqId, kickCqId;
  logic [NQ-1:0] kickSqMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  qring_doorbell #(.NUM_Q(NQ), .PTR_W(PW), .ADDR_W(AW), .DATA_W(32), .DB_BASE(BASE)) i_qring_doorbell (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sqCreate(sqCreate), .sqDelete(sqDelete), .sqId(sqId), .sqSize(sqSize), .sqCqId(sqCqId),
    .cqCreate(cqCreate), .cqDelete(cqDelete), .cqId(cqId), .cqSize(cqSize), .cqIrqEn(cqIrqEn),
    .sqConsume(sqConsume), .sqConsumeId(sqConsumeId), .cqPost(cqPost), .cqPostId(cqPostId),
    .qSel(qSel),
    .sqValidO(sqValidO), .sqHeadO(sqHeadO), .sqTailO(sqTailO), .sqEmptyO(sqEmptyO),
    .cqValidO(cqValidO), .cqHeadO(cqHeadO), .cqTailO(cqTailO), .cqPhaseO(cqPhaseO),
    .cqFullO(cqFullO), .cqPendingO(cqPendingO),
    .irqValid(irqValid), .irqId(irqId), .kickCqValid(kickCqValid), .kickCqId(kickCqId),
    .kickSqMask(kickSqMask)
  );

  int nChecks = 0;
  int nBad = 0;
  bit done = 0;

  // reference model
  int mSqV[NQ], mSqS[NQ], mSqH[NQ], mSqT[NQ], mSqC[NQ];
  int mCqV[NQ], mCqS[NQ], mCqH[NQ], mCqT[NQ], mCqP[NQ], mCqI[NQ];

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit mFull(input int q);
    if (!mCqV[q]) return 0;
    return ((mCqT[q] + 1) % mCqS[q]) == mCqH[q];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    for (int q = 0; q < NQ; q++) begin
      qSel = QW'(q);
      #1;
      chk({req, " sqValid"}, int'(sqValidO), mSqV[q]);
      chk({req, " sqHead"},  int'(sqHeadO),  mSqH[q]);
      chk({req, " sqTail"},  int'(sqTailO),  mSqT[q]);
      chk({req, " R8 sqEmpty"}, int'(sqEmptyO), (!mSqV[q] || mSqH[q] == mSqT[q]) ? 1 : 0);
      chk({req, " cqValid"}, int'(cqValidO), mCqV[q]);
      chk({req, " cqHead"},  int'(cqHeadO),  mCqH[q]);
      chk({req, " cqTail"},  int'(cqTailO),  mCqT[q]);
      chk({req, " cqPhase"}, int'(cqPhaseO), mCqP[q]);
      chk({req, " R8 cqFull"}, int'(cqFullO), int'(mFull(q)));
      chk({req, " R8 cqPending"}, int'(cqPendingO), (mCqV[q] && mCqT[q] != mCqH[q]) ? 1 : 0);
    end
  endtask

  task automatic idlePulses(input string req);
    chk({req, " irqValid idle"}, int'(irqValid), 0);
    chk({req, " kickCqValid idle"}, int'(kickCqValid), 0);
    chk({req, " kickSqMask idle"}, int'(kickSqMask), 0);
  endtask

  task automatic dbWrite(input int addr, input int data, input string req);
    int q, off, val, mask;
    bit expIrq, expKick, isCq;
    expIrq = 0; expKick = 0; mask = 0; q = 0;
    val = data & 'hffff;
    if (addr >= BASE && (addr % 4) == 0) begin
      off  = addr - BASE;
      q    = off / 8;
      isCq = (off % 8) == 4;
      if (q < NQ) begin
        if (!isCq && mSqV[q] && val < mSqS[q]) mSqT[q] = val;
        if (isCq && mCqV[q] && val < mCqS[q]) begin
          expKick = mFull(q);
          expIrq  = mCqI[q] && (mCqT[q] != val);
          mCqH[q] = val;
          if (expKick)
            for (int s = 0; s < NQ; s++)
              if (mSqV[s] && mSqC[s] == q) mask |= (1 << s);
        end
      end
    end
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = data;
    step();
    wrEn = 1'b0;
    chk({req, " R9 irqValid"}, int'(irqValid), int'(expIrq));
    if (expIrq) chk({req, " R9 irqId"}, int'(irqId), q);
    chk({req, " R10 kickCqValid"}, int'(kickCqValid), int'(expKick));
    if (expKick) chk({req, " R10 kickCqId"}, int'(kickCqId), q);
    chk({req, " R10 kickSqMask"}, int'(kickSqMask), mask);
    checkAll(req);
  endtask

  task automatic createSq(input int q, input int size, input int cq);
    sqCreate = 1'b1; sqId = QW'(q); sqSize = PW'(size); sqCqId = QW'(cq);
    step();
    sqCreate = 1'b0;
    if (size >= 2) begin
      mSqV[q] = 1; mSqS[q] = size; mSqH[q] = 0; mSqT[q] = 0; mSqC[q] = cq;
    end
    idlePulses("R5");
    checkAll("R5");
  endtask

  task automatic createCq(input int q, input int size, input int ien);
    cqCreate = 1'b1; cqId = QW'(q); cqSize = PW'(size); cqIrqEn = ien[0];
    step();
    cqCreate = 1'b0;
    if (size >= 2) begin
      mCqV[q] = 1; mCqS[q] = size; mCqH[q] = 0; mCqT[q] = 0; mCqP[q] = 1; mCqI[q] = ien;
    end
    idlePulses("R5");
    checkAll("R5");
  endtask

  task automatic consume(input int q, input string req);
    sqConsume = 1'b1; sqConsumeId = QW'(q);
    step();
    sqConsume = 1'b0;
    if (mSqV[q] && mSqH[q] != mSqT[q]) mSqH[q] = (mSqH[q] + 1) % mSqS[q];
    idlePulses(req);
    checkAll(req);
  endtask

  task automatic post(input int q, input string req);
    cqPost = 1'b1; cqPostId = QW'(q);
    step();
    cqPost = 1'b0;
    if (mCqV[q] && !mFull(q)) begin
      mCqT[q] = mCqT[q] + 1;
      if (mCqT[q] == mCqS[q]) begin
        mCqT[q] = 0;
        mCqP[q] = 1 - mCqP[q];
      end
    end
    idlePulses(req);
    checkAll(req);
  endtask

  function automatic int sqAddr(input int q);
    return BASE + 8 * q;
  endfunction

  function automatic int cqAddr(input int q);
    return BASE + 8 * q + 4;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    sqCreate = 1'b0; sqDelete = 1'b0; cqCreate = 1'b0; cqDelete = 1'b0; cqIrqEn = 1'b0;
    sqConsume = 1'b0; cqPost = 1'b0;
    sqId = '0; sqCqId = '0; cqId = '0; sqConsumeId = '0; cqPostId = '0; qSel = '0;
    sqSize = '0; cqSize = '0;
    for (int q = 0; q < NQ; q++) begin
      mSqV[q] = 0; mSqS[q] = 0; mSqH[q] = 0; mSqT[q] = 0; mSqC[q] = 0;
      mCqV[q] = 0; mCqS[q] = 0; mCqH[q] = 0; mCqT[q] = 0; mCqP[q] = 0; mCqI[q] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step();
    // R11 reset state
    idlePulses("R11");
    checkAll("R11");

    // R3 doorbells before any queue exists
    dbWrite(sqAddr(0), 1, "R3 uncreated sq");
    dbWrite(cqAddr(0), 1, "R3 uncreated cq");

    // R5 sizes below 2 refused, then real creation
    createCq(2, 1, 1);
    createCq(2, 0, 1);
    createSq(1, 1, 0);
    for (int q = 0; q < NQ; q++) createCq(q, q + 2, (q % 2 == 0) ? 1 : 0);
    createSq(0, 5, 0);
    createSq(1, 4, 1);
    createSq(2, 3, 1);
    createSq(3, 2, 0);

    // R1 R4 R2 submission tail sweep with junk in the upper data bits
    for (int q = 0; q < NQ; q++) begin
      for (int v = 0; v <= mSqS[q] + 1; v++) begin
        dbWrite(sqAddr(q), 'h5A5A0000 | v, "R1 R4 sq tail");
        for (int k = 1; k < 4; k++) dbWrite(sqAddr(q) + k, (v + 1) % mSqS[q], "R2 misaligned");
      end
      dbWrite(sqAddr(q), 0, "R1 sq tail reset");
    end

    // R1 R4 R9 R10 completion head sweep (tail at 0)
    for (int q = 0; q < NQ; q++) begin
      for (int v = 0; v <= mCqS[q] + 1; v++) begin
        dbWrite(cqAddr(q), 'hA5A50000 | v, "R1 R4 cq head");
        dbWrite(cqAddr(q) + 2, 0, "R2 misaligned");
      end
      dbWrite(cqAddr(q), 0, "R1 cq head reset");
    end

    // R3 out of range and R1 below window
    dbWrite(sqAddr(NQ), 1, "R3 range");
    dbWrite(cqAddr(NQ), 1, "R3 range");
    dbWrite(sqAddr(NQ + 3), 0, "R3 range");
    dbWrite(BASE - 8, 1, "R1 below window");
    dbWrite(BASE - 4, 1, "R1 below window");

    // R6 consume with wraparound and consume on empty
    for (int q = 0; q < NQ; q++) begin
      for (int r = 0; r < 3; r++) begin
        dbWrite(sqAddr(q), (mSqH[q] + mSqS[q] - 1) % mSqS[q], "R6 refill");
        for (int c = 0; c < mSqS[q]; c++) consume(q, "R6 consume");
      end
    end

    // R7 R9 R10 post with wraparound, phase, full handling
    for (int q = 0; q < NQ; q++) begin
      for (int r = 0; r < 3 * mCqS[q]; r++) begin
        post(q, "R7 post");
        if (mFull(q)) begin
          post(q, "R7 post on full");
          dbWrite(cqAddr(q), (mCqH[q] + 1) % mCqS[q], "R10 partial head");
          post(q, "R7 refill");
          dbWrite(cqAddr(q), mCqT[q], "R10 head catch-up");
        end
      end
    end

    // R10 mask excludes deleted submission queues
    sqDelete = 1'b1; sqId = 2'd1;
    step();
    sqDelete = 1'b0;
    mSqV[1] = 0;
    checkAll("R3 delete sq");
    for (int c = 0; c < mCqS[1]; c++) post(1, "R7 fill");
    dbWrite(cqAddr(1), (mCqH[1] + 1) % mCqS[1], "R10 mask after delete");
    dbWrite(sqAddr(1), 0, "R3 deleted sq");
    consume(1, "R3 consume deleted");

    // R3 deleted completion queue
    cqDelete = 1'b1; cqId = 2'd1;
    step();
    cqDelete = 1'b0;
    mCqV[1] = 0;
    checkAll("R3 delete cq");
    dbWrite(cqAddr(1), 0, "R3 deleted cq");
    post(1, "R3 post deleted");

    done = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule